// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional 8-bit ports, A and B. Each port has its own capture register. The register is loaded from that port's bus on the rising edge of a capture clock that belongs to that port alone. An active-low output enable and a direction input choose which port, if either, the block drives. For each direction, a select input chooses what the driven port carries. It is either the live value on the opposite bus or the value stored in the opposite bus's register.

Capture does not depend on the enable or the direction. Data can therefore be stored while both ports are isolated, or while a port is being driven by the block itself. A parameter chooses a true or an inverting data path. The tri-state pads are modelled as separate input, output and output-enable vectors for each port.

Top module: `regd_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab`, the A register loads `a_in`. On each rising edge of `clk_ba`, the B register loads `b_in`. The two clocks are independent, and both may rise at the same instant.
- R2: Capture happens whatever the values of `oe_n` and `dir`, including while a port is driven. A port that the block drives stores the block's own output value.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are all zeros.
- R4: While `oe_n` is 0, `dir`=1 gives `b_oe` all ones and `a_oe` all zeros, and `dir`=0 gives the reverse. Each enable vector is always all ones or all zeros, and the two are never asserted together.
- R5: When port B is driven, `sel_ab`=0 puts the live `a_in` on `b_out`, and `sel_ab`=1 puts the A register on `b_out`.
- R6: When port A is driven, `sel_ba`=0 puts the live `b_in` on `a_out`, and `sel_ba`=1 puts the B register on `a_out`.
- R7: With `INVERT`=0, the driven output equals the selected source. With `INVERT`=1, it is the bitwise complement of the selected source, on both the live path and the stored path.
- R8: In stored mode, the driven output shows a newly captured value right after the capture edge, with no further edge needed.
- R9: `rst_n`=0 clears both registers to zero at once, without waiting for a clock edge. Before the next capture, a stored-mode output then reads 0x00 (true) or 0xFF (inverting).
- R10: The select of the direction that is not active has no effect on the driven port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A register |
| clk_ba | input | 1 | Capture clock of the B register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1: drive port B; 0: drive port A |
| sel_ab | input | 1 | Source for B: 0 live A bus, 1 A register |
| sel_ba | input | 1 | Source for A: 0 live B bus, 1 B register |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value the block drives onto A |
| a_oe | output | WIDTH | Output enable of the A pads |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value the block drives onto B |
| b_oe | output | WIDTH | Output enable of the B pads |

## Verification
The main function is exercised in isolation, in both drive directions, and in live and stored mode. Captures are made on the A clock alone, on the B clock alone, and on both clocks at the same edge. Stored-mode reads that follow an earlier capture confirm that each register loaded its own bus and no other. A capture made in the same cycle as a stored-mode read shows that the output follows that edge. A capture taken while the port is driven by the block shows that the register takes the block's own output rather than the external value. A true instance and an inverting instance run the same stimulus. Because the expected values differ between the two, any path that skips or doubles the complement is caught.

// File: rtl/regd_xcvr.sv
module regd_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] hold_a, hold_b;
  logic [WIDTH-1:0] pick_a, pick_b;
  logic             drive_a, drive_b;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) hold_a <= '0;
    else        hold_a <= a_in;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) hold_b <= '0;
    else        hold_b <= b_in;

  assign pick_b = sel_ab ? hold_a : a_in;
  assign pick_a = sel_ba ? hold_b : b_in;

  generate
    if (INVERT) begin : g_inv
      assign b_out = ~pick_b;
      assign a_out = ~pick_a;
    end else begin : g_true
      assign b_out = pick_b;
      assign a_out = pick_a;
    end
  endgenerate

  assign drive_b = ~oe_n &  dir;
  assign drive_a = ~oe_n & ~dir;
  assign b_oe    = {WIDTH{drive_b}};
  assign a_oe    = {WIDTH{drive_a}};

endmodule

// File: rtl/regd_xcvr_chk.sv
module regd_xcvr_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             rst_n,
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] b_oe,
  input logic [WIDTH-1:0] hold_a,
  input logic [WIDTH-1:0] hold_b
);

  function automatic logic [WIDTH-1:0] fx(input logic [WIDTH-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  p_isolate_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  p_uniform_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (a_oe == '0 || &a_oe) && (b_oe == '0 || &b_oe) && !(|a_oe && |b_oe));

  p_dir_b_r4: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && dir) |-> (&b_oe && a_oe == '0));

  p_dir_a_r4: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir) |-> (&a_oe && b_oe == '0));

  p_live_ab_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir && !sel_ab) |-> b_out == fx(a_in));

  p_stored_ab_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir && sel_ab) |-> b_out == fx(hold_a));

  p_live_ba_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir && !sel_ba) |-> a_out == fx(b_in));

  p_stored_ba_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir && sel_ba) |-> a_out == fx(hold_b));

endmodule

bind regd_xcvr regd_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .hold_a(hold_a), .hold_b(hold_b)
);

// File: tb/test_regd_xcvr.sv
module test_regd_xcvr;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba = 1'b0;
  logic oe_n = 1'b0, dir = 1'b1, sel_ab = 1'b1, sel_ba = 1'b1;
  logic [7:0] a_ext = 8'h00, b_ext = 8'h00;
  wire cap_ab = clk & en_ab;
  wire cap_ba = clk & en_ba;

  logic [7:0] a_in_w[2], a_out_w[2], a_oe_w[2];
  logic [7:0] b_in_w[2], b_out_w[2], b_oe_w[2];

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      a_in_w[k] = (|a_oe_w[k]) ? a_out_w[k] : a_ext;
      b_in_w[k] = (|b_oe_w[k]) ? b_out_w[k] : b_ext;
    end
  end

  regd_xcvr #(.WIDTH(8), .INVERT(1'b0)) i_regd_xcvr (
    .rst_n(rst_n), .clk_ab(cap_ab), .clk_ba(cap_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in_w[0]), .a_out(a_out_w[0]),
    .a_oe(a_oe_w[0]), .b_in(b_in_w[0]), .b_out(b_out_w[0]), .b_oe(b_oe_w[0]));

  regd_xcvr #(.WIDTH(8), .INVERT(1'b1)) i_regd_xcvr_inv (
    .rst_n(rst_n), .clk_ab(cap_ab), .clk_ba(cap_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in_w[1]), .a_out(a_out_w[1]),
    .a_oe(a_oe_w[1]), .b_in(b_in_w[1]), .b_out(b_out_w[1]), .b_oe(b_oe_w[1]));

  int total = 0, bad = 0;
  logic [7:0] sha[2], shb[2];

  // {oe_n, dir, sel_ab, sel_ba, cap_a, cap_b, 2'b0, a_ext, b_ext}
  localparam logic [23:0] VEC [13] = '{
    24'h88_3C_A5, 24'h84_11_5A, 24'h8C_C3_96, 24'h40_7E_00,
    24'h60_01_FF, 24'h68_E7_00, 24'h44_29_00, 24'h00_FF_4D,
    24'h10_00_12, 24'h14_00_B4, 24'h1C_5F_6E, 24'hB0_AA_55,
    24'h60_00_00
  };

  function automatic logic [7:0] fx(input int inv, input logic [7:0] v);
    return (inv != 0) ? ~v : v;
  endfunction

  task automatic ck(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] v, input string note);
    logic da, db;
    logic [7:0] pa, pb;
    @(negedge clk);
    oe_n = v[23]; dir = v[22]; sel_ab = v[21]; sel_ba = v[20];
    en_ab = v[19]; en_ba = v[18]; a_ext = v[15:8]; b_ext = v[7:0];
    db = !oe_n && dir;
    da = !oe_n && !dir;
    for (int k = 0; k < 2; k++) begin
      pa = da ? fx(k, sel_ba ? shb[k] : b_ext) : a_ext;
      pb = db ? fx(k, sel_ab ? sha[k] : a_ext) : b_ext;
      if (en_ab) sha[k] = pa;
      if (en_ba) shb[k] = pb;
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      string vt;
      vt = (k == 1) ? "R7 inverting" : "R7 true";
      ck($sformatf("%s %s a_oe", oe_n ? "R3" : "R4", note), a_oe_w[k], {8{da}});
      ck($sformatf("%s %s b_oe", oe_n ? "R3" : "R4", note), b_oe_w[k], {8{db}});
      if (db)
        ck($sformatf("R5 %s %s %s", sel_ab ? "stored" : "live", vt, note),
           b_out_w[k], fx(k, sel_ab ? sha[k] : a_ext));
      if (da)
        ck($sformatf("R6 %s %s %s", sel_ba ? "stored" : "live", vt, note),
           a_out_w[k], fx(k, sel_ba ? shb[k] : b_ext));
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin sha[k] = 8'h00; shb[k] = 8'h00; end
    a_ext = 8'h5A;
    #12;
    ck("R9 reset stored B true", b_out_w[0], 8'h00);
    ck("R9 reset stored B inverting", b_out_w[1], 8'hFF);
    ck("R4 reset a_oe", a_oe_w[0], 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) step(VEC[i], $sformatf("R1 vec%0d", i));

    step(24'h68_9C_00, "R8 same-edge stored");
    step(24'h64_4B_00, "R8 B captures own output");
    step(24'h08_00_C8, "R2 A captures own output");
    step(24'h60_00_00, "R2 readback of own output");
    step(24'h40_33_00, "R10 base");
    step(24'h50_33_00, "R10 other select high");
    step(24'h00_00_21, "R10 A base");
    step(24'h20_00_21, "R10 A other select high");

    @(negedge clk);
    en_ab = 1'b0; en_ba = 1'b0;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1;
    rst_n = 1'b0;
    #1;
    ck("R9 async clear true", b_out_w[0], 8'h00);
    ck("R9 async clear inverting", b_out_w[1], 8'hFF);
    for (int k = 0; k < 2; k++) begin sha[k] = 8'h00; shb[k] = 8'h00; end
    @(negedge clk);
    rst_n = 1'b1;
    step(24'h70_00_00, "R9 after reset");
    @(negedge clk);
    en_ab = 1'b0; en_ba = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule